// File: doc/BRIEF.md
# Three-wire serial EEPROM word reader

This block fetches 16-bit words from a three-wire serial EEPROM. It drives chip select, shift clock and serial data toward the memory and samples the memory's serial output. A host supplies a word address, an address-width choice and a one-cycle start pulse. The block shifts out a read opcode and the address, then shifts in sixteen data bits. It returns the word together with a one-cycle done pulse.

A second entry point loads the station address without host help. It first reads word 0 with an 8-bit address. If that word equals a fixed signature, the part is taken to use 8-bit addresses; otherwise it uses 6-bit addresses. The sequence then reads words 7, 8 and 9 with the detected width and packs them into a 48-bit station address.

A divider input sets how many system clocks each half of the shift clock lasts, so the same block can serve slow and fast memories.

Top module: `mw_eeprom_rd`

## Requirements
- R1: After reset, chip select, shift clock and serial data out are low; busy, done and autoload-done are low; the data word, the station address and the detected-width flag are zero.
- R2: Each access shifts out, MSB first, the opcode bits 1,1,0 followed by the address: 8 bits `addr_i[7:0]` when `wide_addr_i`=1, or 6 bits `addr_i[5:0]` when `wide_addr_i`=0. Each command bit is placed on the data line while the clock is low, and the data line never changes while the clock is high.
- R3: After the command, the block reads 16 data bits, MSB first. Each bit is sampled at the end of a clock-high half. A manual read puts the word on `data_o` and pulses `done_o` for exactly one cycle, in a cycle where `busy_o` is low.
- R4: Every high and every low half of the shift clock lasts at least `div_i`+1 system clocks, with `div_i` captured at the start of each access. For div=0 the shortest half is one clock; for div=3 it is four clocks.
- R5: Chip select goes high for exactly one pulse per access and is low again once the access completes. The shift clock is never high while chip select is low. Each access makes 3+W+16 rising clock edges, where W is the address width in use.
- R6: A `start_i` or `autoload_i` pulse that arrives while `busy_o` is high is ignored. No further access is started, and `data_o` and `wide_o` still reflect only the access already in progress.
- R7: An autoload first reads word 0 with an 8-bit address. It sets `wide_o`=1 if that word equals 0x8129, and sets `wide_o`=0 otherwise.
- R8: The autoload then reads words 7, 8 and 9 with the detected width and pulses `al_done_o` once. Octet k of the station address sits in `station_o[8k+7:8k]`, and each word contributes its low byte first, so `station_o` = {word9, word8, word7}. During an autoload, `done_o` does not pulse and `data_o` keeps its value.
- R9: Once a start is accepted, `busy_o` stays high until its completion pulse, and is low in every cycle in which the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 8 | Shift-clock half period minus one, in system clocks |
| start_i | input | 1 | Pulse: begin a manual word read |
| addr_i | input | 8 | Word address for a manual read |
| wide_addr_i | input | 1 | 1 = 8-bit address, 0 = 6-bit address (manual reads) |
| autoload_i | input | 1 | Pulse: begin width detection and station-address load |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM shift clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| busy_o | output | 1 | An access or autoload is in progress |
| done_o | output | 1 | One-cycle pulse when a manual read completes |
| data_o | output | 16 | Word from the last manual read |
| al_done_o | output | 1 | One-cycle pulse when an autoload completes |
| wide_o | output | 1 | Detected address width: 1 = 8 bits |
| station_o | output | 48 | Station address loaded by autoload |

## Verification
A wrong command register or bit counter shows up at the memory pins within one access. The model then records a wrong opcode, a wrong address or a wrong edge count, and returns a word that does not match the expected one. A wrong sampling phase or shift direction corrupts `data_o` as soon as the first read completes. A broken divider changes the measured half-period length during the very first command bit. Sequencer faults appear at the end of the autoload, as a wrong `wide_o` or `station_o`, an extra chip-select pulse, or a stray `done_o`.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam logic [2:0] CMD_READ = 3'b110;

  typedef enum logic [2:0] {
    E_IDLE, E_SETUP, E_CMD_LO, E_CMD_HI, E_RD_LO, E_RD_HI, E_TAIL
  } eng_state_e;

  typedef enum logic [1:0] {
    S_IDLE, S_MAN, S_DET, S_AL
  } seq_state_e;
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_shift_eng.sv
module mw_shift_eng
  import mw_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int AW_MAX = 8,
  parameter int AW_MIN = 6,
  parameter int DW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [AW_MAX-1:0] addr_i,
  input  logic              wide_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              ee_do_i,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  output logic              done_o,
  output logic [DW-1:0]     word_o
);
  localparam int CMD_W = 3 + AW_MAX;
  localparam int CNT_W = $clog2(DW > CMD_W ? DW : CMD_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(3 + AW_MIN - 1);
  localparam logic [CNT_W-1:0] LAST_DATA   = CNT_W'(DW - 1);

  eng_state_e        st_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [CNT_W-1:0]  bit_q;
  logic              wide_q;
  logic [DIV_W-1:0]  div_q;
  logic [DW-1:0]     sh_q;
  logic [DW-1:0]     word_q;
  logic              done_q;
  logic              tick;
  logic [CNT_W-1:0]  cmd_last;
  logic [CMD_W-1:0]  cmd_narrow;

  mw_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != E_IDLE),
    .div_i  (div_q),
    .tick_o (tick)
  );

  assign cmd_last   = wide_q ? LAST_WIDE : LAST_NARROW;
  assign cmd_narrow = CMD_W'({CMD_READ, addr_i[AW_MIN-1:0]}) << (AW_MAX - AW_MIN);

  assign ee_cs_o = (st_q != E_IDLE) && (st_q != E_TAIL);
  assign ee_sk_o = (st_q == E_CMD_HI) || (st_q == E_RD_HI);
  assign ee_di_o = ((st_q == E_CMD_LO) || (st_q == E_CMD_HI)) && cmd_q[CMD_W-1];
  assign done_o  = done_q;
  assign word_o  = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      cmd_q  <= '0;
      bit_q  <= '0;
      wide_q <= 1'b0;
      div_q  <= '0;
      sh_q   <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == E_IDLE) begin
        if (go_i) begin
          st_q   <= E_SETUP;
          wide_q <= wide_i;
          div_q  <= div_i;
          bit_q  <= '0;
          cmd_q  <= wide_i ? {CMD_READ, addr_i} : cmd_narrow;
        end
      end else if (tick) begin
        unique case (st_q)
          E_SETUP:  st_q <= E_CMD_LO;
          E_CMD_LO: st_q <= E_CMD_HI;
          E_CMD_HI: begin
            if (bit_q == cmd_last) begin
              bit_q <= '0;
              st_q  <= E_RD_LO;
            end else begin
              bit_q <= bit_q + 1'b1;
              cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
              st_q  <= E_CMD_LO;
            end
          end
          E_RD_LO: st_q <= E_RD_HI;
          E_RD_HI: begin
            sh_q <= {sh_q[DW-2:0], ee_do_i};
            if (bit_q == LAST_DATA) begin
              st_q <= E_TAIL;
            end else begin
              bit_q <= bit_q + 1'b1;
              st_q  <= E_RD_LO;
            end
          end
          E_TAIL: begin
            st_q   <= E_IDLE;
            word_q <= sh_q;
            done_q <= 1'b1;
          end
          default: st_q <= E_IDLE;
        endcase
      end
    end
  end

  // half-period length monitor
  logic [DIV_W:0] hp_cnt_q;
  logic           sk_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hp_cnt_q  <= '0;
      sk_prev_q <= 1'b0;
    end else begin
      sk_prev_q <= ee_sk_o;
      if (st_q == E_IDLE || ee_sk_o != sk_prev_q) hp_cnt_q <= '0;
      else if (hp_cnt_q != '1)                    hp_cnt_q <= hp_cnt_q + 1'b1;
    end
  end

  // R4
  sk_half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sk_o != sk_prev_q) |-> (hp_cnt_q >= {1'b0, div_q}));

  // R5
  sk_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);

  // R2
  di_stable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sk_o && sk_prev_q) |-> $stable(ee_di_o));
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int          AW_MAX   = 8,
  parameter int          DW       = 16,
  parameter logic [15:0] SIG      = 16'h8129,
  parameter int          ST_BASE  = 7,
  parameter int          ST_WORDS = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   autoload_i,
  input  logic [AW_MAX-1:0]      addr_i,
  input  logic                   wide_i,
  input  logic                   eng_done_i,
  input  logic [DW-1:0]          eng_word_i,
  output logic                   eng_go_o,
  output logic [AW_MAX-1:0]      eng_addr_o,
  output logic                   eng_wide_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   al_done_o,
  output logic [DW-1:0]          data_o,
  output logic                   wide_o,
  output logic [DW*ST_WORDS-1:0] station_o
);
  localparam int IDX_W = (ST_WORDS > 1) ? $clog2(ST_WORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ST_WORDS - 1);

  seq_state_e             st_q;
  logic                   go_q, done_q, al_done_q, det_q, ewide_q;
  logic [AW_MAX-1:0]      eaddr_q;
  logic [IDX_W-1:0]       idx_q;
  logic [DW-1:0]          data_q;
  logic [DW*ST_WORDS-1:0] station_q;

  assign eng_go_o   = go_q;
  assign eng_addr_o = eaddr_q;
  assign eng_wide_o = ewide_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign al_done_o  = al_done_q;
  assign data_o     = data_q;
  assign wide_o     = det_q;
  assign station_o  = station_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      go_q      <= 1'b0;
      done_q    <= 1'b0;
      al_done_q <= 1'b0;
      det_q     <= 1'b0;
      ewide_q   <= 1'b0;
      eaddr_q   <= '0;
      idx_q     <= '0;
      data_q    <= '0;
      station_q <= '0;
    end else begin
      go_q      <= 1'b0;
      done_q    <= 1'b0;
      al_done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (start_i) begin
            st_q    <= S_MAN;
            go_q    <= 1'b1;
            eaddr_q <= addr_i;
            ewide_q <= wide_i;
          end else if (autoload_i) begin
            st_q    <= S_DET;
            go_q    <= 1'b1;
            eaddr_q <= '0;
            ewide_q <= 1'b1;
          end
        end
        S_MAN: if (eng_done_i) begin
          data_q <= eng_word_i;
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        S_DET: if (eng_done_i) begin
          det_q   <= (eng_word_i == SIG);
          ewide_q <= (eng_word_i == SIG);
          eaddr_q <= AW_MAX'(ST_BASE);
          idx_q   <= '0;
          go_q    <= 1'b1;
          st_q    <= S_AL;
        end
        S_AL: if (eng_done_i) begin
          station_q[idx_q*DW +: DW] <= eng_word_i;
          if (idx_q == IDX_LAST) begin
            al_done_q <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            eaddr_q <= eaddr_q + 1'b1;
            go_q    <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  al_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_done_o |-> !done_o);

  // R6
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !eng_go_o || $past(st_q) != S_MAN);
endmodule

// File: rtl/mw_eeprom_rd.sv
module mw_eeprom_rd #(
  parameter int          DIV_W    = 8,
  parameter int          AW_MAX   = 8,
  parameter int          AW_MIN   = 6,
  parameter int          DW       = 16,
  parameter logic [15:0] SIG      = 16'h8129,
  parameter int          ST_BASE  = 7,
  parameter int          ST_WORDS = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [DIV_W-1:0]       div_i,
  input  logic                   start_i,
  input  logic [AW_MAX-1:0]      addr_i,
  input  logic                   wide_addr_i,
  input  logic                   autoload_i,
  input  logic                   ee_do_i,
  output logic                   ee_cs_o,
  output logic                   ee_sk_o,
  output logic                   ee_di_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [DW-1:0]          data_o,
  output logic                   al_done_o,
  output logic                   wide_o,
  output logic [DW*ST_WORDS-1:0] station_o
);
  logic              eng_go, eng_wide, eng_done;
  logic [AW_MAX-1:0] eng_addr;
  logic [DW-1:0]     eng_word;

  mw_seq #(
    .AW_MAX(AW_MAX), .DW(DW), .SIG(SIG), .ST_BASE(ST_BASE), .ST_WORDS(ST_WORDS)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .autoload_i (autoload_i),
    .addr_i     (addr_i),
    .wide_i     (wide_addr_i),
    .eng_done_i (eng_done),
    .eng_word_i (eng_word),
    .eng_go_o   (eng_go),
    .eng_addr_o (eng_addr),
    .eng_wide_o (eng_wide),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .al_done_o  (al_done_o),
    .data_o     (data_o),
    .wide_o     (wide_o),
    .station_o  (station_o)
  );

  mw_shift_eng #(
    .DIV_W(DIV_W), .AW_MAX(AW_MAX), .AW_MIN(AW_MIN), .DW(DW)
  ) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (eng_go),
    .addr_i  (eng_addr),
    .wide_i  (eng_wide),
    .div_i   (div_i),
    .ee_do_i (ee_do_i),
    .ee_cs_o (ee_cs_o),
    .ee_sk_o (ee_sk_o),
    .ee_di_o (ee_di_o),
    .done_o  (eng_done),
    .word_o  (eng_word)
  );

  // R9
  busy_cover_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_go |-> busy_o);
endmodule

// File: tb/tb_mw_eeprom_rd.sv
module tb_mw_eeprom_rd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div = 8'd3;
  logic        start = 1'b0;
  logic [7:0]  addr = '0;
  logic        wide = 1'b1;
  logic        autoload = 1'b0;
  logic        ee_do = 1'b0;
  logic        ee_cs, ee_sk, ee_di, busy, done, al_done, wide_det;
  logic [15:0] data;
  logic [47:0] station;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mw_eeprom_rd dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .start_i(start), .addr_i(addr),
    .wide_addr_i(wide), .autoload_i(autoload), .ee_do_i(ee_do),
    .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .busy_o(busy),
    .done_o(done), .data_o(data), .al_done_o(al_done), .wide_o(wide_det),
    .station_o(station)
  );

  // EEPROM model
  logic [15:0] mem [256];
  int          model_aw = 8;
  bit          al_track = 0;
  int          edge_n = 0, last_edges = 0, cs_rises = 0;
  logic [15:0] cmd_sr = '0, out_word = '0;
  logic [2:0]  last_op = '0;
  logic [7:0]  cap_addr = '0;

  always @(posedge ee_cs) begin
    edge_n = 0; cmd_sr = '0; cs_rises++;
  end
  always @(negedge ee_cs) begin
    last_edges = edge_n;
    if (al_track) begin
      model_aw = (mem[0] == 16'h8129) ? 8 : 6;
      al_track = 0;
    end
  end
  always @(posedge ee_sk) if (ee_cs) begin
    if (edge_n < 3 + model_aw) begin
      cmd_sr = {cmd_sr[14:0], ee_di};
      if (edge_n == 3 + model_aw - 1) begin
        last_op  = cmd_sr[model_aw +: 3];
        cap_addr = (model_aw == 8) ? cmd_sr[7:0] : {2'b00, cmd_sr[5:0]};
      end
    end else begin
      automatic int j = edge_n - (3 + model_aw);
      if (j == 0) out_word = mem[cap_addr];
      if (j < 16) ee_do = out_word[15-j];
    end
    edge_n++;
  end

  // half-period and done monitors
  int run = 0, min_run = 1000, done_cnt = 0;
  logic sk_last = 1'b0;
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (ee_cs) begin
      if (ee_sk == sk_last) run++;
      else begin
        if (run < min_run) min_run = run;
        run = 1;
      end
    end else run = 0;
    sk_last = ee_sk;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_flag(bit al);
    int k = 0;
    while (k < 20000 && !(al ? al_done : done)) begin
      @(negedge clk); k++;
    end
    check("R9 completion seen", k < 20000, 1);
  endtask

  task automatic do_read(logic [7:0] a, logic w, logic [7:0] d, string tag);
    int r0;
    int aw = w ? 8 : 6;
    logic [7:0] ea = w ? a : {2'b00, a[5:0]};
    model_aw = aw; div = d; min_run = 1000; r0 = cs_rises;
    @(negedge clk); addr = a; wide = w; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R9 busy after start"}, busy, 1);
    wait_flag(0);
    check({tag, " R3 data"}, data, mem[ea]);
    check({tag, " R3 done with busy low"}, busy, 0);
    check({tag, " R2 opcode"}, last_op, 3'b110);
    check({tag, " R2 address"}, cap_addr, ea);
    check({tag, " R5 edge count"}, last_edges, 3 + aw + 16);
    check({tag, " R5 one cs pulse"}, cs_rises - r0, 1);
    check({tag, " R5 cs low after"}, ee_cs, 0);
    check({tag, " R4 min half period"}, min_run, d + 1);
    @(negedge clk);
    check({tag, " R3 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    check("R1 cs", ee_cs, 0);
    check("R1 sk", ee_sk, 0);
    check("R1 di", ee_di, 0);
    check("R1 busy/done", {busy, done, al_done}, 0);
    check("R1 data", data, 0);
    check("R1 station", station, 0);
    check("R1 wide", wide_det, 0);
  endtask

  task automatic t_ignore();
    int r0 = cs_rises;
    logic w0 = wide_det;
    model_aw = 8; div = 8'd2;
    @(negedge clk); addr = 8'h33; wide = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    addr = 8'h44; start = 1'b1; autoload = 1'b1;
    @(negedge clk); start = 1'b0; autoload = 1'b0;
    wait_flag(0);
    check("R6 data from first access", data, mem[8'h33]);
    repeat (60) @(negedge clk);
    check("R6 no extra access", cs_rises - r0, 1);
    check("R6 wide unchanged", wide_det, w0);
    check("R6 idle", busy, 0);
  endtask

  task automatic t_autoload(logic [15:0] w0, string tag);
    int r0 = cs_rises, d0 = done_cnt;
    logic [15:0] data0 = data;
    logic exp_w = (w0 == 16'h8129);
    mem[0] = w0; model_aw = 8; al_track = 1; div = 8'd1;
    @(negedge clk); autoload = 1'b1;
    @(negedge clk); autoload = 1'b0;
    wait_flag(1);
    check({tag, " R7 wide"}, wide_det, exp_w);
    check({tag, " R8 station"}, station, {mem[9], mem[8], mem[7]});
    check({tag, " R8 octet0 low byte w7"}, station[7:0], mem[7][7:0]);
    check({tag, " R8 cs pulses"}, cs_rises - r0, 4);
    check({tag, " R8 last edges"}, last_edges, (exp_w ? 8 : 6) + 19);
    check({tag, " R8 no done"}, done_cnt - d0, 0);
    check({tag, " R8 data kept"}, data, data0);
    @(negedge clk);
    check({tag, " R8 al_done one cycle"}, al_done, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0d2b) ^ 16'hA5C3;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    do_read(8'h5A, 1'b1, 8'd3, "wide");
    do_read(8'hC5, 1'b0, 8'd3, "narrow");
    do_read(8'hFF, 1'b1, 8'd0, "div0");
    do_read(8'h3F, 1'b0, 8'd5, "div5");
    t_ignore();
    t_autoload(16'h8129, "sig");
    t_autoload(16'h1234, "nosig");
    do_read(8'h07, 1'b0, 8'd1, "after_al");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule